// File: doc/BRIEF.md
# Two-Channel Wiper Code Controller with Two-Wire Serial Access

This block is a two-wire serial bus slave that holds the 8-bit tap codes for two variable-resistor channels. It also drives two general-purpose logic levels and reports the shutdown state of each channel. A master loads a channel by sending an instruction byte and then a data byte. The instruction byte picks the channel and can also return that channel to midscale, put it into software shutdown, and set the two logic levels. A read transaction returns the stored code of the last channel the master selected.

The bus lines are sampled with the system clock, which must run many times faster than the bus clock. Each line passes through a configurable synchronizer. SDA is driven as an output enable: when it is high, the line is pulled low. An active-low shutdown pin overrides the effective tap codes of both channels through a purely combinational path and leaves the stored codes as they are.

Top module: `i2c_dual_wiper_ctrl`

## Requirements
- R1: When the synchronous active-low reset is applied, both stored codes become 80h, both logic levels become 0, software shutdown is cleared on both channels, channel A is selected and SDA is released.
- R2: The 7-bit slave address is the ADDR_PREFIX parameter (default 01011b) followed by strap_i[1] and then strap_i[0]. The eighth bit of the address byte is the direction: 1 means read, 0 means write. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: After an address that does not match, the slave acknowledges nothing and changes nothing until the next START.
- R4: In a write, the instruction byte is acknowledged. Its bit 7 selects the channel (0 = A, 1 = B). Its bit 4 drives logic_o[0] and its bit 3 drives logic_o[1]. These take effect when the instruction is acknowledged.
- R5: The data byte that follows an instruction is acknowledged and is loaded into the selected channel's stored code when it is acknowledged. Further instruction and data pairs in the same transaction are handled in the same way.
- R6: Instruction bit 6 set to 1 loads 80h into the selected channel's stored code.
- R7: Instruction bit 5 sets (1) or clears (0) the software shutdown of the selected channel. While a channel is in shutdown, its tap output reads 00h and its shdn_act_o bit is 1, but its stored code is kept and can still be read back.
- R8: While shdn_n_i is low, both tap outputs read 00h and both shdn_act_o bits are 1, in the same cycle and without any clock edge. The stored codes do not change, and they reappear when the pin is released.
- R9: A read returns the stored code of the selected channel, MSB first, and repeats it for as long as the master acknowledges. After a NACK the slave releases SDA.
- R10: A STOP, or a repeated START, at any bit position returns the slave to idle or to address reception. SDA is released and no register changes.
- R11: SDA is pulled low only during an acknowledge bit the slave gives or during a read data bit that is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 2 | Low two address bits from strap pins |
| shdn_n_i | input | 1 | Active-low shutdown, acts on both channels combinationally |
| wiper_a_o | output | 8 | Effective tap code of channel A |
| wiper_b_o | output | 8 | Effective tap code of channel B |
| shdn_act_o | output | 2 | Shutdown indication per channel (bit 0 = A) |
| logic_o | output | 2 | General-purpose logic levels |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and the 01011b address prefix. The strap pins are held at 10b, so a wrong strap value and a wrong prefix each give an address that must be refused. With the default synchronizer depth, a register update lands about four system clocks after the SCL edge. The bench bit period of 24 system clocks therefore leaves room for the reference model to be compared on every clock outside a short settling window after each acknowledged byte. The same bit period leaves room for mid-byte STOP and repeated-START cases.

// File: rtl/wiperctl_pkg.sv
// Shared constants and types for the two-channel wiper code controller.
// Assumes byte-wide bus transfers and exactly two channels.
package wiperctl_pkg;

    localparam int unsigned CODE_W = 8;
    localparam logic [CODE_W-1:0] MIDSCALE = 8'h80;

    // Bit positions inside the instruction byte
    localparam int unsigned INS_SEL  = 7;
    localparam int unsigned INS_MID  = 6;
    localparam int unsigned INS_SHDN = 5;
    localparam int unsigned INS_LO0  = 4;
    localparam int unsigned INS_LO1  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_t;

endpackage

// File: rtl/wiperctl_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain. From the
// synchronized levels it derives SCL edges, START and STOP.
// Assumes the system clock is many times faster than SCL and SYNC_STAGES >= 2.
module wiperctl_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_s, sda_s, scl_q, sda_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            // One synchronizer stage per line; idle-high reset value
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_i;
                    sda_pipe[g] <= sda_i;
                end else begin
                    scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
                    sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~scl_q;
    assign scl_fall_o = ~scl_s & scl_q;
    assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/wiperctl_bus_fsm.sv
// Byte-level slave engine: address match, instruction and data reception,
// read-data shifting, acknowledge generation.
// Assumes the edge and START/STOP strobes come from wiperctl_line_sync.
module wiperctl_bus_fsm
    import wiperctl_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start,
    input  logic              stop,
    input  logic              sda_s,
    input  logic [1:0]        strap,
    input  logic [CODE_W-1:0] rd_code,
    output logic              sda_oe,
    output logic              instr_we,
    output logic              data_we,
    output logic [CODE_W-1:0] rx_byte
);

    localparam logic [3:0] BITS = 4'(CODE_W);

    bus_state_t        state;
    logic [CODE_W-1:0] sh;
    logic [3:0]        cnt;
    logic              rw;
    logic              mack;

    // Main bus state machine; START and STOP take priority everywhere
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sh       <= '0;
            cnt      <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            instr_we <= 1'b0;
            data_we  <= 1'b0;
        end else begin
            instr_we <= 1'b0;
            data_we  <= 1'b0;
            if (start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_INSTR, ST_DATA: begin
                        if (scl_rise && cnt < BITS) begin
                            sh  <= {sh[CODE_W-2:0], sda_s};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == BITS) begin
                            cnt <= '0;
                            case (state)
                                ST_ADDR: begin
                                    if (sh[CODE_W-1:1] == {ADDR_PREFIX, strap}) begin
                                        sda_oe <= 1'b1;
                                        rw     <= sh[0];
                                        state  <= ST_ADDR_ACK;
                                    end else begin
                                        state  <= ST_IGNORE;
                                    end
                                end
                                ST_INSTR: begin
                                    sda_oe   <= 1'b1;
                                    instr_we <= 1'b1;
                                    state    <= ST_INSTR_ACK;
                                end
                                default: begin
                                    sda_oe  <= 1'b1;
                                    data_we <= 1'b1;
                                    state   <= ST_DATA_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                sh     <= rd_code;
                                sda_oe <= ~rd_code[CODE_W-1];
                                state  <= ST_RD_BYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_INSTR;
                            end
                        end
                    end
                    ST_INSTR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_DATA;
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_INSTR;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == BITS) begin
                                cnt    <= '0;
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                sh     <= {sh[CODE_W-2:0], 1'b0};
                                sda_oe <= ~sh[CODE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                sh     <= rd_code;
                                sda_oe <= ~rd_code[CODE_W-1];
                                state  <= ST_RD_BYTE;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rx_byte = sh;

    // R11: SDA pulled low only in acknowledge or read-data states
    p_oe_states_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_INSTR_ACK ||
                    state == ST_DATA_ACK || state == ST_RD_BYTE));

    // R10: STOP lands in idle with SDA released
    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state == ST_IDLE && !sda_oe));

    // R10: START restarts address reception from bit zero
    p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_ADDR && cnt == 4'd0 && !sda_oe));

    // R3: while ignoring, no acknowledge and no register write
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && !instr_we && !data_we));

endmodule

// File: rtl/wiperctl_regs.sv
// Stored tap codes, channel select, software shutdown and logic levels.
// Updated only by the instruction and data strobes from the bus engine.
module wiperctl_regs
    import wiperctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_we,
    input  logic              data_we,
    input  logic [CODE_W-1:0] rx_byte,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic [1:0]        sw_shdn,
    output logic [1:0]        logic_lvl,
    output logic [CODE_W-1:0] rd_code
);

    logic [CODE_W-1:0] code_q [2];
    logic              sel;

    // Channel select and logic levels follow each instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel       <= 1'b0;
            logic_lvl <= 2'b00;
        end else if (instr_we) begin
            sel       <= rx_byte[INS_SEL];
            logic_lvl <= {rx_byte[INS_LO1], rx_byte[INS_LO0]};
        end
    end

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_chan
            localparam logic CH_ID = (g == 1);
            // Per-channel stored code: midscale command or data load
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    code_q[g] <= MIDSCALE;
                end else if (instr_we && rx_byte[INS_SEL] == CH_ID && rx_byte[INS_MID]) begin
                    code_q[g] <= MIDSCALE;
                end else if (data_we && sel == CH_ID) begin
                    code_q[g] <= rx_byte;
                end
            end
            // Per-channel software shutdown flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sw_shdn[g] <= 1'b0;
                end else if (instr_we && rx_byte[INS_SEL] == CH_ID) begin
                    sw_shdn[g] <= rx_byte[INS_SHDN];
                end
            end
        end
    endgenerate

    assign code_a  = code_q[0];
    assign code_b  = code_q[1];
    assign rd_code = sel ? code_q[1] : code_q[0];

    // R8: stored codes hold whenever no strobe arrives
    p_codes_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_we && !data_we) |=> ($stable(code_a) && $stable(code_b)));

    // R5: instruction and data strobes never coincide
    p_we_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_we && data_we));

    // R5: a data strobe makes the selected code equal the received byte
    p_data_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |=> (rd_code == $past(rx_byte)));

endmodule

// File: rtl/i2c_dual_wiper_ctrl.sv
// Top level: two-wire slave controlling two tap codes, two logic levels and
// per-channel shutdown. The shutdown pin reaches the outputs combinationally.
// Assumes clk oversamples SCL by a wide margin.
module i2c_dual_wiper_ctrl
    import wiperctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [4:0]  ADDR_PREFIX = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        strap_i,
    input  logic              shdn_n_i,
    output logic [CODE_W-1:0] wiper_a_o,
    output logic [CODE_W-1:0] wiper_b_o,
    output logic [1:0]        shdn_act_o,
    output logic [1:0]        logic_o
);

    logic              sda_s, scl_rise, scl_fall, start, stop;
    logic              instr_we, data_we;
    logic [CODE_W-1:0] rx_byte, rd_code, code_a, code_b;
    logic [1:0]        sw_shdn;

    wiperctl_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop)
    );

    wiperctl_bus_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start    (start),
        .stop     (stop),
        .sda_s    (sda_s),
        .strap    (strap_i),
        .rd_code  (rd_code),
        .sda_oe   (sda_oe_o),
        .instr_we (instr_we),
        .data_we  (data_we),
        .rx_byte  (rx_byte)
    );

    wiperctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_we  (instr_we),
        .data_we   (data_we),
        .rx_byte   (rx_byte),
        .code_a    (code_a),
        .code_b    (code_b),
        .sw_shdn   (sw_shdn),
        .logic_lvl (logic_o),
        .rd_code   (rd_code)
    );

    // Effective outputs: pin or software shutdown forces the B end (00h)
    always_comb begin
        shdn_act_o = {2{~shdn_n_i}} | sw_shdn;
        wiper_a_o  = shdn_act_o[0] ? '0 : code_a;
        wiper_b_o  = shdn_act_o[1] ? '0 : code_b;
    end

endmodule

// File: tb/i2c_dual_wiper_ctrl_test.sv
`timescale 1ns/1ps
module i2c_dual_wiper_ctrl_test;

    localparam int H = 12;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, scl, m_sda, shdn_n;
    logic [1:0] strap;
    logic       sda_oe;
    logic [7:0] wa, wb;
    logic [1:0] sact, lo;
    wire        sda_line = m_sda & ~sda_oe;

    i2c_dual_wiper_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(strap), .shdn_n_i(shdn_n),
        .wiper_a_o(wa), .wiper_b_o(wb), .shdn_act_o(sact), .logic_o(lo)
    );

    int checks = 0, fails = 0, cyc = 0, hold_until = 0;
    bit cmp_on = 0, done = 0;

    logic [7:0] m_code [2];
    logic       m_sw [2];
    logic [1:0] m_lo;
    logic       m_sel;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] eff(int ch);
        return (!shdn_n || m_sw[ch]) ? 8'h00 : m_code[ch];
    endfunction

    // Reference model compared on every clock outside the settling window
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cmp_on && cyc >= hold_until) begin
            chk("R5 model wiper_a", wa, eff(0));
            chk("R5 model wiper_b", wb, eff(1));
            chk("R7 model shdn_act", sact, {(!shdn_n || m_sw[1]), (!shdn_n || m_sw[0])});
            chk("R4 model logic", lo, m_lo);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_cycle(input logic b, output logic s);
        tick(H/2); m_sda = b;
        tick(H/2); scl = 1'b1;
        tick(H);   s = sda_line; scl = 1'b0;
    endtask

    task automatic start_c();
        tick(H/2); m_sda = 1'b1;
        tick(H/2); scl = 1'b1;
        tick(H);   m_sda = 1'b0;
        tick(H);   scl = 1'b0;
    endtask

    task automatic stop_c();
        tick(H/2); m_sda = 1'b0;
        tick(H/2); scl = 1'b1;
        tick(H);   m_sda = 1'b1;
        tick(H);
    endtask

    // kind: 0 plain, 1 instruction, 2 data (model update at the ACK)
    task automatic send_byte(input logic [7:0] b, input int kind, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        if (kind == 1) begin
            m_sel = b[7];
            m_lo = {b[3], b[4]};
            m_sw[b[7]] = b[5];
            if (b[6]) m_code[b[7]] = 8'h80;
        end else if (kind == 2) begin
            m_code[m_sel] = b;
        end
        hold_until = cyc + 10;
        bit_cycle(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            d[i] = s;
        end
        bit_cycle(~mack, s);
    endtask

    localparam logic [6:0] ADR = {5'b01011, 2'b10};

    initial begin
        logic       ack;
        logic [7:0] d;
        logic       s;
        rst_n = 0; scl = 1; m_sda = 1; shdn_n = 1; strap = 2'b10;
        m_code[0] = 8'h80; m_code[1] = 8'h80; m_sw[0] = 0; m_sw[1] = 0;
        m_lo = 2'b00; m_sel = 0;
        tick(5);
        rst_n = 1;
        tick(3);
        chk("R1 wiper_a", wa, 8'h80);
        chk("R1 wiper_b", wb, 8'h80);
        chk("R1 logic", lo, 2'b00);
        chk("R1 shdn_act", sact, 2'b00);
        chk("R1 sda_oe", sda_oe, 1'b0);
        cmp_on = 1;

        // R2 R4 R5: two instruction/data pairs in one write
        start_c();
        send_byte({ADR, 1'b0}, 0, ack); chk("R2 address ack", ack, 1);
        send_byte(8'h18, 1, ack);       chk("R4 instr ack", ack, 1);
        send_byte(8'h3C, 2, ack);       chk("R5 data ack", ack, 1);
        tick(H);
        chk("R5 wiper_a loaded", wa, 8'h3C);
        chk("R4 logic levels", lo, 2'b11);
        send_byte(8'h88, 1, ack);       chk("R5 second instr ack", ack, 1);
        send_byte(8'hA5, 2, ack);       chk("R5 second data ack", ack, 1);
        stop_c();
        chk("R5 wiper_b loaded", wb, 8'hA5);
        chk("R4 logic levels second", lo, 2'b10);

        // R3: wrong strap bits and wrong prefix
        start_c();
        send_byte({5'b01011, 2'b01, 1'b0}, 0, ack); chk("R3 strap mismatch nack", ack, 0);
        send_byte(8'h40, 0, ack);                   chk("R3 ignored byte nack", ack, 0);
        send_byte(8'h00, 0, ack);                   chk("R3 ignored byte2 nack", ack, 0);
        stop_c();
        start_c();
        send_byte({5'b01010, 2'b10, 1'b0}, 0, ack); chk("R3 prefix mismatch nack", ack, 0);
        send_byte(8'hC0, 0, ack);                   chk("R3 ignored byte3 nack", ack, 0);
        stop_c();
        chk("R3 wiper_a kept", wa, 8'h3C);
        chk("R3 wiper_b kept", wb, 8'hA5);

        // R6: midscale command on channel A
        start_c();
        send_byte({ADR, 1'b0}, 0, ack);
        send_byte(8'h40, 1, ack);
        stop_c();
        chk("R6 wiper_a midscale", wa, 8'h80);

        // R7: software shutdown of channel B, stored code readable
        start_c();
        send_byte({ADR, 1'b0}, 0, ack);
        send_byte(8'hA0, 1, ack);
        stop_c();
        chk("R7 wiper_b forced", wb, 8'h00);
        chk("R7 shdn_act", sact, 2'b10);
        start_c();
        send_byte({ADR, 1'b1}, 0, ack); chk("R2 read address ack", ack, 1);
        recv_byte(1'b1, d);             chk("R7 R9 read stored code", d, 8'hA5);
        recv_byte(1'b0, d);             chk("R9 repeated read", d, 8'hA5);
        tick(8);
        chk("R9 sda released after nack", sda_oe, 0);
        stop_c();
        start_c();
        send_byte({ADR, 1'b0}, 0, ack);
        send_byte(8'h80, 1, ack);
        stop_c();
        chk("R7 wiper_b restored", wb, 8'hA5);

        // R8: asynchronous shutdown pin
        shdn_n = 0; #1;
        chk("R8 wiper_a forced", wa, 8'h00);
        chk("R8 wiper_b forced", wb, 8'h00);
        chk("R8 shdn_act both", sact, 2'b11);
        tick(5);
        shdn_n = 1; #1;
        chk("R8 wiper_a restored", wa, 8'h80);
        chk("R8 wiper_b restored", wb, 8'hA5);

        // R10: repeated START mid data byte, STOP mid instruction
        start_c();
        send_byte({ADR, 1'b0}, 0, ack);
        send_byte(8'h00, 1, ack);
        for (int i = 0; i < 4; i++) bit_cycle(1'b1, s);
        start_c();
        tick(8);
        chk("R10 sda released after restart", sda_oe, 0);
        send_byte({ADR, 1'b0}, 0, ack); chk("R10 address after restart", ack, 1);
        for (int i = 0; i < 3; i++) bit_cycle(1'b1, s);
        stop_c();
        chk("R10 wiper_a unchanged", wa, 8'h80);
        chk("R10 logic unchanged", lo, 2'b00);
        start_c();
        send_byte({ADR, 1'b1}, 0, ack);
        recv_byte(1'b0, d);             chk("R9 read channel A", d, 8'h80);
        stop_c();
        tick(20);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule